// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces the PAR bit and its output enable for a PCI device that can act as either initiator or target. It checks the PAR bit it receives when it is the target of a write. It watches the 32-bit address/data bus, the 4-bit command/byte-enable bus, the IRDY/TRDY handshake and a set of qualifiers. Those qualifiers give the device's role, the transfer direction and whether the current clock is an address phase. Tristate behaviour is modelled with explicit enable outputs, and every handshake input is active-high: 1 means asserted on the bus.

The parity covers the 36 bits of a phase and is driven exactly one clock after that phase. Whether a phase is covered depends on the device's role and the transfer direction. When the device is a write target, the PAR received one clock after a completed data phase is compared against the locally computed value. A mismatch has three effects:
- PERR is driven for one clock, if PERR driving is enabled.
- A sticky detected-error status bit is set.
- A one-clock interrupt request pulse is raised on the NMI or SMI line chosen by configuration.

An external PERR also raises the selected interrupt, but it does not set the detected-error status.

Top module: `pci_parity_unit`

## Requirements
- R1: PAR makes the count of ones across adBus, cbeBus and PAR even, and all 36 bits count regardless of which byte enables are active.
- R2: In the clock after an address phase (addrPhase=1) in which isInitiator=1, parOe is 1 and parOut carries the parity of that phase.
- R3: In the clock after a completed data phase, parOe is 1 only when the device is initiator of a write (isInitiator=1, isWrite=1) or target of a read (isTarget=1, isWrite=0). After a target write or an initiator read it stays 0.
- R4: A data phase is complete only on a clock where irdyAct and trdyAct are both 1. A wait-state clock with either of them at 0 causes neither a parity drive nor a check.
- R5: After a completed target-write data phase, parIn is compared during the next clock. On a mismatch with perrEnable=1, perrOut and perrOe are 1 for exactly one clock, the clock after that. With perrEnable=0, or with matching parity, they stay 0.
- R6: statusErr is set by a detected mismatch and stays set until a clock with statClr=1 and no new mismatch. A new mismatch in the same clock as statClr leaves it set. External PERR does not set it.
- R7: intSel selects the interrupt: 1 selects NMI, 2 selects SMI, and 0 or 3 select none. Each error event gives a single-clock pulse on the selected request only. For a detected mismatch the pulse comes in the same clock as the PERR drive. For an external PERR (perrInAct=1) it comes in the clock after.
- R8: While rstN is 0, parOe, parOut, perrOe, perrOut, statusErr, nmiReq and smiReq are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| adBus | input | 32 | Address/data bus value this clock |
| cbeBus | input | 4 | Command/byte-enable bus value this clock |
| addrPhase | input | 1 | This clock is an address phase |
| isInitiator | input | 1 | Device is initiator of the current transaction |
| isTarget | input | 1 | Device is target of the current transaction |
| isWrite | input | 1 | Current transaction is a write |
| irdyAct | input | 1 | IRDY asserted on the bus |
| trdyAct | input | 1 | TRDY asserted on the bus |
| parIn | input | 1 | PAR value received from the bus |
| perrInAct | input | 1 | PERR asserted by another device |
| perrEnable | input | 1 | Configuration: allow PERR driving |
| intSel | input | 2 | Configuration: 0 none, 1 NMI, 2 SMI, 3 none |
| statClr | input | 1 | Write-one-to-clear for the status bit |
| parOut | output | 1 | Generated PAR value |
| parOe | output | 1 | PAR output enable |
| perrOut | output | 1 | PERR asserted value when driven |
| perrOe | output | 1 | PERR output enable |
| statusErr | output | 1 | Sticky detected-parity-error status |
| nmiReq | output | 1 | NMI request pulse |
| smiReq | output | 1 | SMI request pulse |

## Verification
Some rules are checked by assertions on every clock:
- every driven PAR makes the previous phase's 36 bits plus PAR even;
- a drive strobe is always followed by the output enable;
- PERR is never driven without a prior enable;
- the status bit holds unless cleared;
- NMI and SMI never pulse together.

Other behaviour can only be shown by the bench's directed scenarios:
- whether a given role and direction pair drives, checks, or does neither;
- that wait states are ignored;
- the exact two-clock placement of PERR;
- which interrupt line pulses for each selection;
- that external PERR leaves the status alone.

// File: rtl/pci_parity_pkg.sv
package pci_parity_pkg;

  // Strobes from control to datapath for the current clock's phase
  typedef struct packed {
    logic driveStb;   // phase is covered by a PAR we drive next clock
    logic checkStb;   // phase is covered by a PAR we check next clock
  } parStrobe_t;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_NMI  = 2'd1,
    IRQ_SMI  = 2'd2,
    IRQ_OFF  = 2'd3
  } irqSel_e;

endpackage

// File: rtl/pci_parity_datapath.sv
module pci_parity_datapath
  import pci_parity_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adBus,
  input  logic [DATA_W/8-1:0] cbeBus,
  input  parStrobe_t        strobe,
  input  logic              parIn,
  output logic              parOut,
  output logic              parOe,
  output logic              mismatch
);

  localparam int LANES = DATA_W / 8;

  // Each byte lane folds its 8 data bits with its own enable bit
  logic [LANES-1:0] laneParity;
  logic             phaseParity;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneParity[g] = ^{adBus[g*8 +: 8], cbeBus[g]};
    end
  endgenerate

  assign phaseParity = ^laneParity;

  logic parReg, parOeReg, expParReg, chkPendReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parReg     <= 1'b0;
      parOeReg   <= 1'b0;
      expParReg  <= 1'b0;
      chkPendReg <= 1'b0;
    end else begin
      parOeReg   <= strobe.driveStb;
      parReg     <= strobe.driveStb ? phaseParity : 1'b0;
      chkPendReg <= strobe.checkStb;
      expParReg  <= phaseParity;
    end
  end

  assign parOut   = parReg;
  assign parOe    = parOeReg;
  assign mismatch = chkPendReg && (parIn != expParReg);

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> ((^{$past(adBus), $past(cbeBus), parOut}) == 1'b0)); // R1

  AST_DRIVE_NEXT_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveStb |=> parOe); // R2

endmodule

// File: rtl/pci_parity_ctrl.sv
module pci_parity_ctrl
  import pci_parity_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrPhase,
  input  logic       isInitiator,
  input  logic       isTarget,
  input  logic       isWrite,
  input  logic       irdyAct,
  input  logic       trdyAct,
  input  logic       mismatch,
  input  logic       perrInAct,
  input  logic       perrEnable,
  input  logic [1:0] intSel,
  input  logic       statClr,
  output parStrobe_t strobe,
  output logic       perrOut,
  output logic       perrOe,
  output logic       statusErr,
  output logic       nmiReq,
  output logic       smiReq
);

  logic dataDone, weSource, errEvent;

  assign dataDone = irdyAct && trdyAct && !addrPhase;
  assign weSource = (isInitiator && isWrite) || (isTarget && !isWrite);

  always_comb begin
    strobe.driveStb = (addrPhase && isInitiator) || (dataDone && weSource);
    strobe.checkStb = dataDone && isTarget && isWrite;
  end

  assign errEvent = mismatch || perrInAct;

  logic perrDrvReg, statusReg, nmiReg, smiReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perrDrvReg <= 1'b0;
      statusReg  <= 1'b0;
      nmiReg     <= 1'b0;
      smiReg     <= 1'b0;
    end else begin
      perrDrvReg <= mismatch && perrEnable;
      statusReg  <= (statusReg && !statClr) || mismatch;
      nmiReg     <= errEvent && (intSel == IRQ_NMI);
      smiReg     <= errEvent && (intSel == IRQ_SMI);
    end
  end

  assign perrOut   = perrDrvReg;
  assign perrOe    = perrDrvReg;
  assign statusErr = statusReg;
  assign nmiReq    = nmiReg;
  assign smiReq    = smiReg;

  AST_PERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    perrOe |-> $past(perrEnable)); // R5

  AST_PERR_WITH_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    perrOe |-> statusErr); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusErr && !statClr) |=> statusErr); // R6

  AST_IRQ_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(nmiReq && smiReq)); // R7

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_parity_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adBus,
  input  logic [3:0]  cbeBus,
  input  logic        addrPhase,
  input  logic        isInitiator,
  input  logic        isTarget,
  input  logic        isWrite,
  input  logic        irdyAct,
  input  logic        trdyAct,
  input  logic        parIn,
  input  logic        perrInAct,
  input  logic        perrEnable,
  input  logic [1:0]  intSel,
  input  logic        statClr,
  output logic        parOut,
  output logic        parOe,
  output logic        perrOut,
  output logic        perrOe,
  output logic        statusErr,
  output logic        nmiReq,
  output logic        smiReq
);

  parStrobe_t strobe;
  logic       mismatch;

  pci_parity_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addrPhase(addrPhase), .isInitiator(isInitiator),
    .isTarget(isTarget), .isWrite(isWrite), .irdyAct(irdyAct), .trdyAct(trdyAct),
    .mismatch(mismatch), .perrInAct(perrInAct), .perrEnable(perrEnable),
    .intSel(intSel), .statClr(statClr), .strobe(strobe), .perrOut(perrOut),
    .perrOe(perrOe), .statusErr(statusErr), .nmiReq(nmiReq), .smiReq(smiReq)
  );

  pci_parity_datapath #(.DATA_W(32)) uData (
    .clk(clk), .rstN(rstN), .adBus(adBus), .cbeBus(cbeBus), .strobe(strobe),
    .parIn(parIn), .parOut(parOut), .parOe(parOe), .mismatch(mismatch)
  );

endmodule

// File: tb/pci_parity_unit_test.sv
`timescale 1ns/1ps
module pci_parity_unit_test;

  logic clk = 1'b0;
  logic rstN;
  logic [31:0] adBus;
  logic [3:0]  cbeBus;
  logic addrPhase, isInitiator, isTarget, isWrite, irdyAct, trdyAct;
  logic parIn, perrInAct, perrEnable, statClr;
  logic [1:0] intSel;
  logic parOut, parOe, perrOut, perrOe, statusErr, nmiReq, smiReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pci_parity_unit uut (
    .clk(clk), .rstN(rstN), .adBus(adBus), .cbeBus(cbeBus), .addrPhase(addrPhase),
    .isInitiator(isInitiator), .isTarget(isTarget), .isWrite(isWrite),
    .irdyAct(irdyAct), .trdyAct(trdyAct), .parIn(parIn), .perrInAct(perrInAct),
    .perrEnable(perrEnable), .intSel(intSel), .statClr(statClr),
    .parOut(parOut), .parOe(parOe), .perrOut(perrOut), .perrOe(perrOe),
    .statusErr(statusErr), .nmiReq(nmiReq), .smiReq(smiReq)
  );

  function automatic logic refPar(logic [31:0] a, logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return logic'(ones % 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    addrPhase = 0; isInitiator = 0; isTarget = 0; isWrite = 0;
    irdyAct = 0; trdyAct = 0; perrInAct = 0; statClr = 0;
  endtask

  // Set a phase at a falling edge; returns at the next falling edge with inputs idle
  task automatic phase(logic [31:0] a, logic [3:0] c, logic ap, logic ini, logic tg,
                       logic wr, logic ir, logic tr);
    adBus = a; cbeBus = c; addrPhase = ap; isInitiator = ini; isTarget = tg;
    isWrite = wr; irdyAct = ir; trdyAct = tr;
    @(negedge clk);
    idle();
  endtask

  task automatic testReset();
    rstN = 0; idle(); adBus = '0; cbeBus = '0; parIn = 0; perrEnable = 1; intSel = 2'd1;
    repeat (3) @(negedge clk);
    chk("R8 parOe", parOe, 0);
    chk("R8 perrOe", perrOe, 0);
    chk("R8 status", statusErr, 0);
    chk("R8 irq", {nmiReq, smiReq}, 0);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic testAddrPhase();
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001};
    logic [3:0]  cbes [4] = '{4'h0, 4'hF, 4'h6, 4'h7};
    foreach (pats[i]) begin
      phase(pats[i], cbes[i], 1, 1, 0, 0, 0, 0);
      chk("R2 parOe after addr", parOe, 1);
      chk("R1 par value", parOut, refPar(pats[i], cbes[i]));
    end
    phase(32'h0, 4'hF, 0, 1, 0, 1, 1, 1);   // byte enables all off still count
    chk("R1 cbe counted", parOut, 1'b0);
    phase(32'h0, 4'hE, 0, 1, 0, 1, 1, 1);
    chk("R1 cbe counted odd", parOut, 1'b1);
    @(negedge clk);
    chk("R2 parOe released", parOe, 0);
  endtask

  task automatic testDirections();
    phase(32'hA5A5_0F0F, 4'h3, 0, 1, 0, 1, 1, 1);
    chk("R3 initiator write drives", parOe, 1);
    chk("R3 initiator write value", parOut, refPar(32'hA5A5_0F0F, 4'h3));
    phase(32'h0000_0007, 4'h0, 0, 0, 1, 0, 1, 1);
    chk("R3 target read drives", parOe, 1);
    chk("R3 target read value", parOut, 1'b1);
    phase(32'h0000_0007, 4'h0, 0, 1, 0, 0, 1, 1);
    chk("R3 initiator read silent", parOe, 0);
    parIn = refPar(32'h0000_0007, 4'h0);
    phase(32'h0000_0007, 4'h0, 0, 0, 1, 1, 1, 1);
    chk("R3 target write silent", parOe, 0);
    @(negedge clk);
  endtask

  task automatic testWaitStates();
    perrEnable = 1; parIn = 1'b1;    // would mismatch if checked (data has even ones)
    phase(32'h0000_0003, 4'h0, 0, 1, 0, 1, 1, 0);
    chk("R4 trdy low no drive", parOe, 0);
    phase(32'h0000_0003, 4'h0, 0, 1, 0, 1, 0, 1);
    chk("R4 irdy low no drive", parOe, 0);
    phase(32'h0000_0003, 4'h0, 0, 0, 1, 1, 0, 1);
    @(negedge clk);
    chk("R4 wait state no check", perrOe, 0);
    chk("R4 wait state no status", statusErr, 0);
  endtask

  // Target write with given received parity error flag; checks PERR/irq placement
  task automatic targetWrite(logic [31:0] a, logic [3:0] c, logic bad, logic en,
                             logic [1:0] sel);
    logic expErr;
    perrEnable = en; intSel = sel;
    phase(a, c, 0, 0, 1, 1, 1, 1);
    parIn = refPar(a, c) ^ bad;     // PAR arrives one clock after the phase
    chk("R5 no perr yet", perrOe, 0);
    @(negedge clk);
    expErr = bad;
    chk("R5 perrOe", perrOe, expErr && en);
    chk("R5 perrOut", perrOut, expErr && en);
    chk("R7 nmi", nmiReq, expErr && (sel == 2'd1));
    chk("R7 smi", smiReq, expErr && (sel == 2'd2));
    if (bad) chk("R6 status set", statusErr, 1);
    @(negedge clk);
    chk("R5 perr one clock", perrOe, 0);
    chk("R7 pulse one clock", {nmiReq, smiReq}, 0);
  endtask

  task automatic testTargetWrite();
    targetWrite(32'hDEAD_BEEF, 4'h5, 0, 1, 2'd1);
    chk("R5 good parity no status", statusErr, 0);
    targetWrite(32'hDEAD_BEEF, 4'h5, 1, 1, 2'd1);
    targetWrite(32'h0102_0408, 4'hA, 1, 0, 2'd2);
    targetWrite(32'h0102_0408, 4'hA, 1, 1, 2'd0);
    targetWrite(32'h0102_0408, 4'hA, 1, 1, 2'd3);
  endtask

  task automatic testStatus();
    chk("R6 still set", statusErr, 1);
    statClr = 1; @(negedge clk); statClr = 0;
    chk("R6 cleared", statusErr, 0);
    // mismatch in same clock as clear: set wins
    perrEnable = 1; intSel = 2'd0;
    phase(32'h1, 4'h0, 0, 0, 1, 1, 1, 1);
    parIn = 1'b0; statClr = 1;
    @(negedge clk); statClr = 0;
    chk("R6 set wins over clear", statusErr, 1);
    statClr = 1; @(negedge clk); statClr = 0;
    chk("R6 cleared again", statusErr, 0);
  endtask

  task automatic testExtPerr();
    intSel = 2'd2; perrInAct = 1;
    @(negedge clk); perrInAct = 0;
    chk("R7 ext perr smi", smiReq, 1);
    chk("R7 ext perr no nmi", nmiReq, 0);
    chk("R6 ext perr no status", statusErr, 0);
    chk("R5 ext perr no drive", perrOe, 0);
    intSel = 2'd1; perrInAct = 1;
    @(negedge clk); perrInAct = 0;
    chk("R7 ext perr nmi", nmiReq, 1);
    @(negedge clk);
    chk("R7 ext pulse ends", nmiReq, 0);
  endtask

  task automatic testMidReset();
    perrEnable = 1;
    phase(32'h1, 4'h0, 0, 0, 1, 1, 1, 1);
    parIn = 1'b0;
    @(negedge clk);
    chk("R6 set before reset", statusErr, 1);
    rstN = 0;
    phase(32'h1, 4'h0, 1, 1, 0, 0, 0, 0);
    chk("R8 status cleared", statusErr, 0);
    chk("R8 no drive in reset", parOe, 0);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testAddrPhase();
    testDirections();
    testWaitStates();
    testTargetWrite();
    testStatus();
    testExtPerr();
    testMidReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule